// File: doc/BRIEF.md
# Parallel Flash Erase-and-Program Sequencer

This block drives a byte-wide parallel flash through a complete rewrite of its address space. After a start pulse it walks every address from zero upward, leaves out a window reserved for I/O, and for each address fetches the byte to be stored from a RAM read port. It then issues the unlock-and-program command writes to the flash through a bus-write request port. Whenever the walk lands on the first byte of a sector, it first issues the unlock-and-erase command writes for that sector. After the erase it waits a fixed settle time and signals progress with a single pulse.

Each command write is a request with address and data that is held until a lower-level bus engine accepts it. The settle times after an erase and after each byte program are given in microseconds and turned into clock counts from a clock-rate parameter. When the walk jumps over the I/O window it raises a half-select output, which picks the upper half of a larger flash part. The run ends when the address wraps past the top of the range. A done level then stays high until the next start.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and in the first sampled cycle after it, `wr_valid`, `ram_req`, `progress`, `done` and `bank_hi` are all 0.
- R2: When the current walk address has its low SECTOR_BITS bits all zero, the block issues six writes before anything else for that address, as (address, data) pairs: (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (UNLOCK_A, 0x80), (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (current address, 0x30).
- R3: Once the last erase write is accepted, at least ERASE_US*CLK_KHZ/1000 full clock cycles pass with no write request and no RAM request. `progress` is then high for exactly one cycle, once per sector.
- R4: For each address the block issues one RAM read (a one-cycle `ram_req` with `ram_addr` equal to the walk address). It then issues four writes: (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (UNLOCK_A, 0xA0), and (current address, the byte returned on `ram_rsp_data` with `ram_rsp_valid`).
- R5: Once the program data write is accepted, at least PROG_US*CLK_KHZ/1000 full cycles pass before the next write request, RAM request or `done`.
- R6: The walk visits addresses in ascending order starting at 0. `bank_hi` is 0 for addresses below HOLE_START, is 1 from the jump to HOLE_END onward, and returns to 0 only on a new start.
- R7: After the last address (all ones) is programmed and its wait ends, `done` rises and stays high with no further requests until `start` is pulsed again. A new start repeats the full walk.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle. A write counts as issued only in a cycle where both are high.
- R9: No write to the current address and no RAM read ever targets an address in [HOLE_START, HOLE_END).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a full walk from idle or done |
| done | output | 1 | High once the walk has finished, until the next start |
| bank_hi | output | 1 | Flash half-select, set when the walk jumps the I/O window |
| progress | output | 1 | One-cycle pulse after each sector erase settles |
| wr_valid | output | 1 | Bus-write request valid |
| wr_addr | output | ADDR_W | Bus-write address |
| wr_data | output | 8 | Bus-write data byte |
| wr_ready | input | 1 | Bus engine accepts the write this cycle |
| ram_req | output | 1 | One-cycle RAM read request |
| ram_addr | output | ADDR_W | RAM read address |
| ram_rsp_valid | input | 1 | RAM read data valid |
| ram_rsp_data | input | 8 | RAM read data |

## Verification
The bench runs the walk with a reduced address width so that the I/O window and the wrap-around fall inside a short run. It targets the jump onto HOLE_END, which is also a sector start. A design that erased only on natural increments would skip that erase, and one that jumped late would read or write inside the window. The ready line is randomly withheld during command writes; a design that moved on without a handshake would drop or reorder command bytes, or change the address mid-request. The gap after each erase and each program is timed, which exposes a design with a short or missing settle wait. A second start after done checks that the half-select clears and the whole walk repeats.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_ERASE_CMD, S_ERASE_WAIT, S_RAM_REQ,
    S_RAM_WAIT, S_PROG_CMD, S_PROG_WAIT, S_DONE
  } seq_state_e;

  typedef enum logic { SEQ_ERASE, SEQ_PROG } seq_kind_e;

  typedef enum logic [1:0] { TGT_UA, TGT_UB, TGT_CUR } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [BYTE_W-1:0] code;
    logic              use_ram;
  } cmd_t;

  // command word for one step of an erase or program sequence
  function automatic cmd_t cmd_lookup(input seq_kind_e kind, input logic [STEP_W-1:0] step);
    cmd_t c;
    c = '{tgt: TGT_UA, code: 8'h00, use_ram: 1'b0};
    if (kind == SEQ_ERASE) begin
      case (step)
        3'd0:    c = '{tgt: TGT_UA,  code: 8'hAA, use_ram: 1'b0};
        3'd1:    c = '{tgt: TGT_UB,  code: 8'h55, use_ram: 1'b0};
        3'd2:    c = '{tgt: TGT_UA,  code: 8'h80, use_ram: 1'b0};
        3'd3:    c = '{tgt: TGT_UA,  code: 8'hAA, use_ram: 1'b0};
        3'd4:    c = '{tgt: TGT_UB,  code: 8'h55, use_ram: 1'b0};
        default: c = '{tgt: TGT_CUR, code: 8'h30, use_ram: 1'b0};
      endcase
    end else begin
      case (step)
        3'd0:    c = '{tgt: TGT_UA,  code: 8'hAA, use_ram: 1'b0};
        3'd1:    c = '{tgt: TGT_UB,  code: 8'h55, use_ram: 1'b0};
        3'd2:    c = '{tgt: TGT_UA,  code: 8'hA0, use_ram: 1'b0};
        default: c = '{tgt: TGT_CUR, code: 8'h00, use_ram: 1'b1};
      endcase
    end
    return c;
  endfunction

  function automatic logic is_final_step(input seq_kind_e kind, input logic [STEP_W-1:0] step);
    return (kind == SEQ_ERASE) ? (step == 3'd5) : (step == 3'd3);
  endfunction

endpackage

// File: rtl/fsc_cmd_table.sv
module fsc_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
  input  seq_kind_e          kind,
  input  logic [STEP_W-1:0]  step,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [BYTE_W-1:0]  ram_byte,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [BYTE_W-1:0]  bus_data,
  output logic               final_step
);

  cmd_t cmd;

  always_comb begin
    cmd        = cmd_lookup(kind, step);
    final_step = is_final_step(kind, step);
    case (cmd.tgt)
      TGT_UA:  bus_addr = UNLOCK_A;
      TGT_UB:  bus_addr = UNLOCK_B;
      default: bus_addr = cur_addr;
    endcase
    bus_data = cmd.use_ram ? ram_byte : cmd.code;
  end

endmodule

// File: rtl/fsc_addr_walk.sv
module fsc_addr_walk #(
  parameter int ADDR_W      = 16,
  parameter int SECTOR_BITS = 12,
  parameter logic [ADDR_W-1:0] HOLE_START = 16'h6000,
  parameter logic [ADDR_W-1:0] HOLE_END   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              bank_hi,
  output logic              at_sector,
  output logic              is_last
);

  logic [ADDR_W-1:0] addr_q, addr_d, addr_inc;
  logic              bank_q, bank_d, hit_hole;

  assign addr_inc = addr_q + ADDR_W'(1);

  generate
    if (HOLE_END > HOLE_START) begin : g_hole
      assign hit_hole = (addr_inc == HOLE_START);
    end else begin : g_no_hole
      assign hit_hole = 1'b0;
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    bank_d = bank_q;
    if (clear) begin
      addr_d = '0;
      bank_d = 1'b0;
    end else if (advance) begin
      if (hit_hole) begin
        addr_d = HOLE_END;
        bank_d = 1'b1;
      end else begin
        addr_d = addr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= 1'b0;
    end else if (clear || advance) begin
      addr_q <= addr_d;
      bank_q <= bank_d;
    end
  end

  assign addr      = addr_q;
  assign bank_hi   = bank_q;
  assign at_sector = (addr_q[SECTOR_BITS-1:0] == '0);
  assign is_last   = &addr_q;

endmodule

// File: rtl/fsc_wait_timer.sv
module fsc_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SECTOR_BITS = 12,
  parameter logic [ADDR_W-1:0] HOLE_START = 16'h6000,
  parameter logic [ADDR_W-1:0] HOLE_END   = 16'h8000,
  parameter logic [ADDR_W-1:0] UNLOCK_A   = 16'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B   = 16'h2AAA,
  parameter int CLK_KHZ  = 50000,
  parameter int ERASE_US = 25000,
  parameter int PROG_US  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              bank_hi,
  output logic              progress,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ready,
  output logic              ram_req,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic              ram_rsp_valid,
  input  logic [7:0]        ram_rsp_data
);

  localparam longint ERASE_CYC = (longint'(CLK_KHZ) * ERASE_US) / 1000;
  localparam longint PROG_CYC  = (longint'(CLK_KHZ) * PROG_US) / 1000;
  localparam longint MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int     CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [BYTE_W-1:0] byte_q;
  logic              step_en, byte_en;

  logic [ADDR_W-1:0] cur_addr, bus_addr;
  logic [BYTE_W-1:0] bus_data;
  logic              at_sector, is_last, final_step;
  logic              walk_clear, walk_adv;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  seq_kind_e         kind;
  logic              accept;

  assign kind   = (state_q == S_ERASE_CMD) ? SEQ_ERASE : SEQ_PROG;
  assign accept = wr_valid && wr_ready;

  fsc_addr_walk #(
    .ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS),
    .HOLE_START(HOLE_START), .HOLE_END(HOLE_END)
  ) u_walk (
    .clk(clk), .rst_n(core_rst_n), .clear(walk_clear), .advance(walk_adv),
    .addr(cur_addr), .bank_hi(bank_hi), .at_sector(at_sector), .is_last(is_last)
  );

  fsc_cmd_table #(
    .ADDR_W(ADDR_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_table (
    .kind(kind), .step(step_q), .cur_addr(cur_addr), .ram_byte(byte_q),
    .bus_addr(bus_addr), .bus_data(bus_data), .final_step(final_step)
  );

  fsc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(core_rst_n), .load(tmr_load),
    .load_val(tmr_val), .expired(tmr_expired)
  );

  assign tmr_val = (state_q == S_ERASE_CMD) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);

  // next-state process
  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    step_en    = 1'b0;
    byte_en    = 1'b0;
    walk_clear = 1'b0;
    walk_adv   = 1'b0;
    tmr_load   = 1'b0;
    progress   = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          walk_clear = 1'b1;
          state_d    = S_CHECK;
        end
      end
      S_CHECK: begin
        step_d  = '0;
        step_en = 1'b1;
        state_d = at_sector ? S_ERASE_CMD : S_RAM_REQ;
      end
      S_ERASE_CMD, S_PROG_CMD: begin
        if (accept) begin
          if (final_step) begin
            tmr_load = 1'b1;
            state_d  = (state_q == S_ERASE_CMD) ? S_ERASE_WAIT : S_PROG_WAIT;
          end else begin
            step_d  = step_q + 3'd1;
            step_en = 1'b1;
          end
        end
      end
      S_ERASE_WAIT: begin
        if (tmr_expired) begin
          progress = 1'b1;
          state_d  = S_RAM_REQ;
        end
      end
      S_RAM_REQ: state_d = S_RAM_WAIT;
      S_RAM_WAIT: begin
        if (ram_rsp_valid) begin
          byte_en = 1'b1;
          step_d  = '0;
          step_en = 1'b1;
          state_d = S_PROG_CMD;
        end
      end
      S_PROG_WAIT: begin
        if (tmr_expired) begin
          walk_adv = 1'b1;
          state_d  = is_last ? S_DONE : S_CHECK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
      if (byte_en) byte_q <= ram_rsp_data;
    end
  end

  assign wr_valid = (state_q == S_ERASE_CMD) || (state_q == S_PROG_CMD);
  assign wr_addr  = bus_addr;
  assign wr_data  = bus_data;
  assign ram_req  = (state_q == S_RAM_REQ);
  assign ram_addr = cur_addr;
  assign done     = (state_q == S_DONE);

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HOLE_START = 16'h6000,
  parameter logic [ADDR_W-1:0] HOLE_END   = 16'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              bank_hi,
  input logic              progress,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_ready,
  input logic              ram_req,
  input logic [ADDR_W-1:0] ram_addr
);

  logic ram_in_hole;
  assign ram_in_hole = (ram_addr >= HOLE_START) && (ram_addr < HOLE_END);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r9_ram_outside_hole: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> !ram_in_hole);

  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |=> !ram_req);

  a_r3_progress_single: assert property (@(posedge clk) disable iff (!rst_n)
    progress |=> !progress);

  a_r3_progress_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    progress |-> !wr_valid && !ram_req);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && !ram_req);

  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r6_bank_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_hi) |-> $past(start));

endmodule

bind flash_cmd_seq fsc_checker #(
  .ADDR_W(ADDR_W), .HOLE_START(HOLE_START), .HOLE_END(HOLE_END)
) i_fsc_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .bank_hi(bank_hi),
  .progress(progress), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ready(wr_ready), .ram_req(ram_req), .ram_addr(ram_addr)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/100ps
module test_flash_cmd_seq;

  localparam int AW = 10;
  localparam int SB = 8;
  localparam logic [AW-1:0] HS = 10'h180;
  localparam logic [AW-1:0] HE = 10'h200;
  localparam logic [AW-1:0] UA = 10'h155;
  localparam logic [AW-1:0] UB = 10'h0AA;
  localparam int KHZ = 1000;
  localparam int E_US = 20;
  localparam int P_US = 3;
  localparam int E_CYC = KHZ * E_US / 1000;
  localparam int P_CYC = KHZ * P_US / 1000;
  localparam int LIMIT = 150000;

  logic clk, rst_n, start, wr_ready, ram_rsp_valid;
  logic [7:0] ram_rsp_data;
  logic done, bank_hi, progress, wr_valid, ram_req;
  logic [AW-1:0] wr_addr, ram_addr;
  logic [7:0] wr_data;

  flash_cmd_seq #(
    .ADDR_W(AW), .SECTOR_BITS(SB), .HOLE_START(HS), .HOLE_END(HE),
    .UNLOCK_A(UA), .UNLOCK_B(UB), .CLK_KHZ(KHZ), .ERASE_US(E_US), .PROG_US(P_US)
  ) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .bank_hi(bank_hi),
    .progress(progress), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .ram_req(ram_req), .ram_addr(ram_addr),
    .ram_rsp_valid(ram_rsp_valid), .ram_rsp_data(ram_rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic [7:0]    data;
    int            kind;   // 0 plain, 1 erase final, 2 program final
    logic          bank;
  } wr_item_t;

  wr_item_t      exp_wr[$];
  logic [AW-1:0] exp_rd[$];
  int total, bad, cyc, prog_seen, exp_sectors, ready_mode;

  function automatic logic [7:0] ram_byte(input logic [AW-1:0] a);
    logic [15:0] m;
    m = 16'(a) * 16'd37 + 16'h5A;
    return m[7:0] ^ 8'(a >> 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d, input int k, input logic b);
    wr_item_t it;
    it.addr = a; it.data = d; it.kind = k; it.bank = b;
    exp_wr.push_back(it);
  endtask

  // expected command stream for one full walk
  task automatic build_expect();
    logic [AW-1:0] a;
    logic          b;
    exp_wr.delete(); exp_rd.delete();
    exp_sectors = 0;
    a = '0; b = 1'b0;
    do begin
      if (a[SB-1:0] == '0) begin
        push_wr(UA, 8'hAA, 0, b); push_wr(UB, 8'h55, 0, b); push_wr(UA, 8'h80, 0, b);
        push_wr(UA, 8'hAA, 0, b); push_wr(UB, 8'h55, 0, b); push_wr(a, 8'h30, 1, b);
        exp_sectors++;
      end
      exp_rd.push_back(a);
      push_wr(UA, 8'hAA, 0, b); push_wr(UB, 8'h55, 0, b); push_wr(UA, 8'hA0, 0, b);
      push_wr(a, ram_byte(a), 2, b);
      a = a + AW'(1);
      if (a == HS) begin a = HE; b = 1'b1; end
    end while (a != '0);
  endtask

  // downstream ready driver
  initial begin
    wr_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      wr_ready = (ready_mode == 0) ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // RAM responder with random latency
  initial begin
    int            lat;
    logic [AW-1:0] pend;
    lat = 0; pend = '0;
    ram_rsp_valid = 1'b0; ram_rsp_data = 8'h00;
    forever begin
      @(posedge clk); #1;
      ram_rsp_valid = 1'b0;
      ram_rsp_data  = 8'($urandom);
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          ram_rsp_valid = 1'b1;
          ram_rsp_data  = ram_byte(pend);
        end
      end
      if (ram_req) begin
        pend = ram_addr;
        lat  = (ready_mode == 0) ? 1 + int'($urandom % 3) : 1;
      end
    end
  end

  // monitor
  logic          prev_stall;
  logic [AW-1:0] prev_addr;
  logic [7:0]    prev_data;
  bit            armed;
  int            arm_cyc, arm_len, erase_cyc;

  initial begin
    prev_stall = 1'b0; prev_addr = '0; prev_data = '0;
    armed = 0; arm_cyc = 0; arm_len = 0; erase_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (prev_stall)
          chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
              "R8 held request", {wr_valid, 7'd0, wr_data, 6'd0, wr_addr}, {1'b1, 7'd0, prev_data, 6'd0, prev_addr});
        if (armed && (wr_valid || ram_req || done)) begin
          chk(cyc - arm_cyc >= arm_len + 1, (arm_len == E_CYC) ? "R3 erase settle" : "R5 program settle",
              cyc - arm_cyc, arm_len + 1);
          armed = 0;
        end
        if (progress) begin
          prog_seen++;
          chk(cyc - erase_cyc >= E_CYC + 1, "R3 progress after settle", cyc - erase_cyc, E_CYC + 1);
        end
        if (wr_valid && wr_addr != UA && wr_addr != UB)
          chk(!(wr_addr >= HS && wr_addr < HE), "R9 write outside window", wr_addr, 0);
        if (ram_req) begin
          chk(!(ram_addr >= HS && ram_addr < HE), "R9 read outside window", ram_addr, 0);
          if (exp_rd.size() == 0) chk(0, "R4 unexpected RAM read", ram_addr, 0);
          else begin
            logic [AW-1:0] ea;
            ea = exp_rd.pop_front();
            chk(ram_addr == ea, "R4 RAM read address", ram_addr, ea);
          end
        end
        if (wr_valid && wr_ready) begin
          if (exp_wr.size() == 0) chk(0, "R7 write after last", wr_addr, 0);
          else begin
            wr_item_t it;
            it = exp_wr.pop_front();
            chk(wr_addr == it.addr, (it.kind == 2 || it.data == 8'hA0) ? "R4 program address" : "R2 command address",
                wr_addr, it.addr);
            chk(wr_data == it.data, (it.kind == 2 || it.data == 8'hA0) ? "R4 program data" : "R2 command data",
                wr_data, it.data);
            chk(bank_hi == it.bank, "R6 half select", bank_hi, it.bank);
            if (it.kind != 0) begin
              armed   = 1;
              arm_cyc = cyc;
              arm_len = (it.kind == 1) ? E_CYC : P_CYC;
              if (it.kind == 1) erase_cyc = cyc;
            end
          end
        end
        prev_stall = wr_valid && !wr_ready;
        prev_addr  = wr_addr;
        prev_data  = wr_data;
      end
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic run_walk(input int mode, input string tag);
    ready_mode = mode;
    build_expect();
    prog_seen = 0;
    pulse_start();
    while (!done && cyc < LIMIT) @(negedge clk);
    if (!done) chk(0, "R7 watchdog expired", 0, 1);
    else begin
      chk(exp_wr.size() == 0, "R7 all writes issued", exp_wr.size(), 0);
      chk(exp_rd.size() == 0, "R4 all reads issued", exp_rd.size(), 0);
      chk(prog_seen == exp_sectors, "R3 progress count", prog_seen, exp_sectors);
      chk(bank_hi == 1'b1, "R6 half select at end", bank_hi, 1);
      repeat (12) @(negedge clk);
      chk(done && !wr_valid && !ram_req, "R7 done holds quietly", {done, wr_valid, ram_req}, 3'b100);
    end
    $display("%s walk finished at cycle %0d", tag, cyc);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    total = 0; bad = 0; cyc = 0; ready_mode = 0;
    start = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({wr_valid, ram_req, progress, done, bank_hi} == 5'b0, "R1 outputs in reset",
        {wr_valid, ram_req, progress, done, bank_hi}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk({wr_valid, ram_req, progress, done, bank_hi} == 5'b0, "R1 outputs after reset",
        {wr_valid, ram_req, progress, done, bank_hi}, 0);
    repeat (4) @(negedge clk);
    chk(!done && !wr_valid, "R7 idle without start", {done, wr_valid}, 0);

    run_walk(0, "random-ready");
    // second start from done: half-select clears and walk repeats
    run_walk(1, "always-ready");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule